// File: doc/BRIEF.md
# Hot-Plug Slot Event Interrupt Logic

This block gathers hot-plug events from a parameterised number of slots. It turns them into a single interrupt line and a single system-error line. Each slot watches its raw status inputs: a two-bit adapter presence code, the attention button, the retention latch sensor, an isolated power fault and a connected power fault. A qualifying edge on any of these inputs is caught in a sticky event latch. Software reads the latches through a simple 32-bit register port and clears them by writing ones. A controller register holds the global masks and two more sticky latches, one for command completion and one for arbiter events.

A read-only locator word tells the service routine where to look. Bit 0 is the command-completion event, and bit i+1 is set when slot i has an event whose interrupt mask is clear. The usual service flow is as follows. Software sets the global interrupt mask, reads the locator, then reads and clears each flagged slot, and finally clears the global mask.

The register port uses word addresses. Address 0 is the controller register, address 1 is the locator, and address 2+i is the register of slot i. Any other address reads as zero and ignores writes.

Top module: `hp_event_irq`

## Requirements
- R1: After reset every slot register reads with bits 30:24 all ones and bits 20:16 zero, the controller register reads 0x0000000F, the locator reads zero, and irq_o and serr_o are low.
- R2: Any change of a slot's two-bit presence input sets that slot's bit 16 at the next clock edge. Any change of its latch sensor input sets bit 19 at the next clock edge.
- R3: A rising edge of the attention button sets slot bit 18, of the isolated fault sets bit 17, and of the connected fault sets bit 20, each at the next clock edge. Falling edges set nothing.
- R4: Writing a 1 to a slot event bit (20:16) clears it, and writing a 0 leaves it unchanged. If a new event arrives in the same cycle as its clearing write, the bit stays set.
- R5: A slot register shows live status: bits 11:10 the presence code (3 means empty), bit 8 the latch sensor (1 means open), bit 7 the button, and bit 6 a power-good flag that reads 0 while either fault input is high.
- R6: Reserved bits always read zero: slot bits 31, 23:21, 15:12, 9 and 5:0, and controller bits 31:18 and 15:4.
- R7: The locator (address 1) reads bit 0 = command latch AND NOT command mask (controller bit 2). It reads bit i+1 = slot i has an event bit set whose interrupt mask (bit 24+k for event bit 16+k) is clear. Writes to it have no effect.
- R8: irq_o is high exactly when the global interrupt mask (controller bit 0) is clear and the locator is non-zero.
- R9: serr_o is high exactly when the global error mask (controller bit 1) is clear and at least one of these holds: a slot latch-change event with that slot's bit 29 clear; a connected-fault event with bit 30 clear; the arbiter latch (controller bit 17) with controller bit 3 clear.
- R10: A high cmd_done input sets controller bit 16 and a high arb_event input sets bit 17 at the next edge. Writing 1 clears each one, and a set in the same cycle wins.
- R11: Writes store slot bits 30:24 and controller bits 3:0 as written, and they read back unchanged.
- R12: Input levels present when reset is released create no events. Edges are only judged from the second clock edge after reset onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| slot_presence | input | 2*NUM_SLOTS | Presence code per slot, slot i at bits 2i+1:2i |
| slot_button | input | NUM_SLOTS | Attention button per slot |
| slot_latch_open | input | NUM_SLOTS | Latch sensor per slot, 1 = open |
| slot_iso_fault | input | NUM_SLOTS | Isolated power fault per slot, active high |
| slot_conn_fault | input | NUM_SLOTS | Connected power fault per slot, active high |
| cmd_done | input | 1 | Command completion indication |
| arb_event | input | 1 | Arbiter event indication |
| irq_o | output | 1 | Interrupt request |
| serr_o | output | 1 | System error request |

## Verification
Some rules are checked on every cycle by the assertions. The global interrupt mask holds irq_o low, and the global error mask holds serr_o low. A non-zero locator read with the global mask clear always comes with an interrupt. Reserved fields read zero. A button rising edge on a primed slot always latches, and that latch never rises without a preceding button level.

Other behaviour needs the bench's scenarios and its reference model. This covers the priority of a new event over a clearing write in the same cycle and the masking of individual events in the locator. It also covers presence and latch-sensor changes in both directions, the silence at reset release, and the arbiter and command latches.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
  // event bit index inside the five-bit event group (decoded by software)
  localparam int EV_PRES  = 0;
  localparam int EV_ISO   = 1;
  localparam int EV_BTN   = 2;
  localparam int EV_LATCH = 3;
  localparam int EV_CONN  = 4;
  localparam int EVT_N    = 5;
  // seven slot masks: five interrupt masks then two error masks
  localparam int MSK_N    = 7;
  localparam int MSK_SERR_LATCH = 5;
  localparam int MSK_SERR_CONN  = 6;
  // field positions in the slot word
  localparam int SLOT_EVT_LSB = 16;
  localparam int SLOT_MSK_LSB = 24;
  // field positions in the controller word
  localparam int CTL_LAT_LSB  = 16;
  localparam int CTL_MSK_N    = 4;
  localparam int CTL_LAT_N    = 2;
  localparam int CM_GINT  = 0;
  localparam int CM_GSERR = 1;
  localparam int CM_CMD   = 2;
  localparam int CM_ARB   = 3;
  localparam int CL_CMD   = 0;
  localparam int CL_ARB   = 1;
  // word map
  localparam int CTRL_ADDR = 0;
  localparam int LOC_ADDR  = 1;
  localparam int SLOT_BASE = 2;

  typedef struct packed {
    logic [1:0] pres;
    logic       btn;
    logic       latch;
    logic       iso;
    logic       conn;
  } slot_raw_t;
endpackage

// File: rtl/hpe_slot.sv
module hpe_slot
  import hpe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             wr_en,
  input  logic [EVT_N-1:0] wr_clr,
  input  logic [MSK_N-1:0] wr_msk,
  input  slot_raw_t        raw,
  output logic [31:0]      rdata,
  output logic [EVT_N-1:0] evt,
  output logic [MSK_N-1:0] msk
);
  slot_raw_t        raw_q;
  logic [EVT_N-1:0] evt_q, evt_d, set_v, clr_v;
  logic [MSK_N-1:0] msk_q;

  // edge detection: any change for presence and latch, rising for the rest
  always_comb begin
    set_v = '0;
    if (armed) begin
      set_v[EV_PRES]  = (raw.pres  != raw_q.pres);
      set_v[EV_LATCH] = (raw.latch != raw_q.latch);
      set_v[EV_BTN]   = raw.btn  & ~raw_q.btn;
      set_v[EV_ISO]   = raw.iso  & ~raw_q.iso;
      set_v[EV_CONN]  = raw.conn & ~raw_q.conn;
    end
    clr_v = wr_en ? wr_clr : '0;
    evt_d = set_v | (evt_q & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      evt_q <= '0;
      msk_q <= '1;
    end else begin
      raw_q <= raw;
      evt_q <= evt_d;
      if (wr_en) msk_q <= wr_msk;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[SLOT_MSK_LSB +: MSK_N] = msk_q;
    rdata[SLOT_EVT_LSB +: EVT_N] = evt_q;
    rdata[11:10] = raw.pres;
    rdata[8]     = raw.latch;
    rdata[7]     = raw.btn;
    rdata[6]     = ~(raw.iso | raw.conn);
  end

  assign evt = evt_q;
  assign msk = msk_q;
endmodule

// File: rtl/hpe_ctrl.sv
module hpe_ctrl
  import hpe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTL_LAT_N-1:0] wr_clr,
  input  logic [CTL_MSK_N-1:0] wr_msk,
  input  logic                 cmd_done,
  input  logic                 arb_event,
  output logic [31:0]          rdata,
  output logic                 gint_mask,
  output logic                 gserr_mask,
  output logic                 cmd_pend,
  output logic                 arb_serr
);
  logic [CTL_MSK_N-1:0] msk_q;
  logic [CTL_LAT_N-1:0] lat_q, lat_d, set_v, clr_v;

  always_comb begin
    set_v         = '0;
    set_v[CL_CMD] = cmd_done;
    set_v[CL_ARB] = arb_event;
    clr_v = wr_en ? wr_clr : '0;
    lat_d = set_v | (lat_q & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= '1;
      lat_q <= '0;
    end else begin
      lat_q <= lat_d;
      if (wr_en) msk_q <= wr_msk;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CTL_MSK_N-1:0]            = msk_q;
    rdata[CTL_LAT_LSB +: CTL_LAT_N] = lat_q;
  end

  assign gint_mask  = msk_q[CM_GINT];
  assign gserr_mask = msk_q[CM_GSERR];
  assign cmd_pend   = lat_q[CL_CMD] & ~msk_q[CM_CMD];
  assign arb_serr   = lat_q[CL_ARB] & ~msk_q[CM_ARB];
endmodule

// File: rtl/hp_event_irq.sv
module hp_event_irq
  import hpe_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [2*NUM_SLOTS-1:0] slot_presence,
  input  logic [NUM_SLOTS-1:0]   slot_button,
  input  logic [NUM_SLOTS-1:0]   slot_latch_open,
  input  logic [NUM_SLOTS-1:0]   slot_iso_fault,
  input  logic [NUM_SLOTS-1:0]   slot_conn_fault,
  input  logic                   cmd_done,
  input  logic                   arb_event,
  output logic                   irq_o,
  output logic                   serr_o
);
  localparam int NUM_WORDS = SLOT_BASE + NUM_SLOTS;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_LOC  = ADDR_W'(LOC_ADDR);

  initial begin
    if (NUM_SLOTS < 1 || NUM_SLOTS > 30 || NUM_WORDS > (1 << ADDR_W))
      $error("hp_event_irq: NUM_SLOTS/ADDR_W out of range");
  end

  logic                         armed_q;
  logic [31:0]                  ctrl_rd;
  logic [31:0]                  slot_rd [NUM_SLOTS];
  logic [EVT_N*NUM_SLOTS-1:0]   evt_all;
  logic [MSK_N*NUM_SLOTS-1:0]   msk_all;
  logic [NUM_SLOTS-1:0]         slot_pend, slot_serr;
  logic                         glb_int_mask, glb_serr_mask, cmd_pend, arb_serr;
  logic                         ctrl_we;
  logic [31:0]                  locator;
  logic                         wdata_unused;

  assign wdata_unused = ^{reg_wdata[31], reg_wdata[23:21], reg_wdata[15:4]};

  // edges are judged only once the previous-value registers hold real data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign ctrl_we = reg_we && (reg_addr == A_CTRL);

  hpe_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctrl_we),
    .wr_clr     (reg_wdata[CTL_LAT_LSB +: CTL_LAT_N]),
    .wr_msk     (reg_wdata[CTL_MSK_N-1:0]),
    .cmd_done   (cmd_done),
    .arb_event  (arb_event),
    .rdata      (ctrl_rd),
    .gint_mask  (glb_int_mask),
    .gserr_mask (glb_serr_mask),
    .cmd_pend   (cmd_pend),
    .arb_serr   (arb_serr)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gen_slot
    localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(SLOT_BASE + s);
    slot_raw_t        raw;
    logic             we_s;
    logic [EVT_N-1:0] ev;
    logic [MSK_N-1:0] mk;

    assign raw.pres  = slot_presence[2*s +: 2];
    assign raw.btn   = slot_button[s];
    assign raw.latch = slot_latch_open[s];
    assign raw.iso   = slot_iso_fault[s];
    assign raw.conn  = slot_conn_fault[s];
    assign we_s      = reg_we && (reg_addr == A_SLOT);

    hpe_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .armed  (armed_q),
      .wr_en  (we_s),
      .wr_clr (reg_wdata[SLOT_EVT_LSB +: EVT_N]),
      .wr_msk (reg_wdata[SLOT_MSK_LSB +: MSK_N]),
      .raw    (raw),
      .rdata  (slot_rd[s]),
      .evt    (ev),
      .msk    (mk)
    );

    assign evt_all[s*EVT_N +: EVT_N] = ev;
    assign msk_all[s*MSK_N +: MSK_N] = mk;
    assign slot_pend[s] = |(evt_all[s*EVT_N +: EVT_N] & ~msk_all[s*MSK_N +: EVT_N]);
    assign slot_serr[s] =
      (evt_all[s*EVT_N + EV_LATCH] & ~msk_all[s*MSK_N + MSK_SERR_LATCH]) |
      (evt_all[s*EVT_N + EV_CONN]  & ~msk_all[s*MSK_N + MSK_SERR_CONN]);
  end

  always_comb begin
    locator              = '0;
    locator[0]           = cmd_pend;
    locator[NUM_SLOTS:1] = slot_pend;
  end

  assign irq_o  = ~glb_int_mask  & (|locator);
  assign serr_o = ~glb_serr_mask & (arb_serr | (|slot_serr));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL)     reg_rdata = ctrl_rd;
    else if (reg_addr == A_LOC) reg_rdata = locator;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (reg_addr == ADDR_W'(SLOT_BASE + s)) reg_rdata = slot_rd[s];
  end
endmodule

// File: rtl/hpe_checker.sv
module hpe_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              irq_o,
  input logic              serr_o,
  input logic              gint_mask,
  input logic              gserr_mask,
  input logic              armed,
  input logic              btn0,
  input logic [4:0]        evt0
);
  localparam int ADDR_LIM = 2 + NUM_SLOTS;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    gint_mask |-> !irq_o) else $error("irq with global mask set"); // R8

  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    gserr_mask |-> !serr_o) else $error("serr with global mask set"); // R9

  AST_LOC_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1) && reg_rdata != 32'd0 && !gint_mask) |-> irq_o)
    else $error("pending locator without irq"); // R7

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(0)) |-> (reg_rdata[31:18] == '0 && reg_rdata[15:4] == '0))
    else $error("controller reserved bits set"); // R6

  AST_SLOT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= 2 && int'(reg_addr) < ADDR_LIM) |->
      (reg_rdata[31] == 1'b0 && reg_rdata[23:21] == '0 && reg_rdata[15:12] == '0 &&
       reg_rdata[9] == 1'b0 && reg_rdata[5:0] == '0))
    else $error("slot reserved bits set"); // R6

  AST_BTN_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(btn0)) |=> evt0[2]) else $error("button edge lost"); // R3

  AST_BTN_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt0[2]) |-> $past(btn0)) else $error("button latch without press"); // R3
endmodule

bind hp_event_irq hpe_checker #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .irq_o      (irq_o),
  .serr_o     (serr_o),
  .gint_mask  (glb_int_mask),
  .gserr_mask (glb_serr_mask),
  .armed      (armed_q),
  .btn0       (slot_button[0]),
  .evt0       (evt_all[4:0])
);

// File: tb/tb_hp_event_irq.sv
`timescale 1ns/1ps
module tb_hp_event_irq;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          we;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [2*N-1:0] pres;
  logic [N-1:0]  btn, mrl, iso, con;
  logic          cdone, arb;
  logic          irq, serr;

  int    vectors = 0;
  int    fails   = 0;
  string cur_req = "R1";
  bit    run     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_event_irq #(.NUM_SLOTS(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .slot_presence(pres), .slot_button(btn),
    .slot_latch_open(mrl), .slot_iso_fault(iso), .slot_conn_fault(con),
    .cmd_done(cdone), .arb_event(arb), .irq_o(irq), .serr_o(serr)
  );

  // ---------------- behavioural reference model ----------------
  logic [4:0] m_evt [N];
  logic [6:0] m_msk [N];
  logic [1:0] p_prs [N];
  logic [N-1:0] p_btn, p_mrl, p_iso, p_con;
  logic       m_armed;
  logic [3:0] m_cm;
  logic [1:0] m_cl;

  always @(posedge clk or negedge rst_n) begin : model
    logic [4:0] st;
    logic [4:0] cl;
    logic       hit;
    if (!rst_n) begin
      for (int s = 0; s < N; s++) begin
        m_evt[s] = '0; m_msk[s] = 7'h7F; p_prs[s] = '0;
      end
      p_btn = '0; p_mrl = '0; p_iso = '0; p_con = '0;
      m_armed = 1'b0; m_cm = 4'hF; m_cl = '0;
    end else begin
      for (int s = 0; s < N; s++) begin
        st = '0;
        if (m_armed) begin
          if (pres[2*s +: 2] != p_prs[s]) st[0] = 1'b1;
          if (iso[s] && !p_iso[s])        st[1] = 1'b1;
          if (btn[s] && !p_btn[s])        st[2] = 1'b1;
          if (mrl[s] != p_mrl[s])         st[3] = 1'b1;
          if (con[s] && !p_con[s])        st[4] = 1'b1;
        end
        hit = we && (int'(addr) == s + 2);
        cl  = hit ? wdata[20:16] : 5'd0;
        m_evt[s] = st | (m_evt[s] & ~cl);
        if (hit) m_msk[s] = wdata[30:24];
        p_prs[s] = pres[2*s +: 2];
      end
      hit = we && (addr == '0);
      m_cl = {arb, cdone} | (m_cl & ~(hit ? wdata[17:16] : 2'b00));
      if (hit) m_cm = wdata[3:0];
      p_btn = btn; p_mrl = mrl; p_iso = iso; p_con = con;
      m_armed = 1'b1;
    end
  end

  function automatic logic [31:0] exp_loc();
    logic [31:0] l = '0;
    l[0] = m_cl[0] & ~m_cm[2];
    for (int s = 0; s < N; s++) l[s+1] = |(m_evt[s] & ~m_msk[s][4:0]);
    return l;
  endfunction

  function automatic logic exp_irq();
    return !m_cm[0] && (exp_loc() != 0);
  endfunction

  function automatic logic exp_serr();
    logic any = m_cl[1] & ~m_cm[3];
    for (int s = 0; s < N; s++)
      any |= (m_evt[s][3] & ~m_msk[s][5]) | (m_evt[s][4] & ~m_msk[s][6]);
    return !m_cm[1] && any;
  endfunction

  function automatic logic [31:0] exp_rd();
    int a = int'(addr);
    if (a == 0) return {14'd0, m_cl, 12'd0, m_cm};
    if (a == 1) return exp_loc();
    if (a >= 2 && a < 2 + N) begin
      int s = a - 2;
      return {1'b0, m_msk[s], 3'd0, m_evt[s], 4'd0, pres[2*s +: 2], 1'b0,
              mrl[s], btn[s], ~(iso[s] | con[s]), 6'd0};
    end
    return 32'd0;
  endfunction

  // compare away from the active edge
  always @(negedge clk) begin
    if (run) begin
      logic [31:0] er;
      logic ei, es;
      er = exp_rd(); ei = exp_irq(); es = exp_serr();
      vectors++;
      if (rdata !== er) begin
        fails++;
        $display("FAIL %s: rdata @addr %0d actual=%h expected=%h", cur_req, addr, rdata, er);
      end
      if (irq !== ei) begin
        fails++;
        $display("FAIL %s: irq_o actual=%b expected=%b", cur_req, irq, ei);
      end
      if (serr !== es) begin
        fails++;
        $display("FAIL %s: serr_o actual=%b expected=%b", cur_req, serr, es);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd(int a, int n = 1);
    addr = AW'(a); cyc(n);
  endtask

  task automatic wr(int a, logic [31:0] d);
    we = 1'b1; addr = AW'(a); wdata = d; cyc();
    we = 1'b0; wdata = '0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    pres = {2'b11, 2'b11, 2'b11, 2'b10}; btn = 4'b0100; mrl = '0;
    iso = '0; con = '0; cdone = 1'b0; arb = 1'b0;
    #2 run = 1'b1;
    cur_req = "R1";
    rd(0); rd(1); rd(2); rd(4);
    rst_n = 1'b1;
    cur_req = "R1";  rd(0); rd(1);
    cur_req = "R12"; rd(2, 2); rd(4, 2); rd(1);

    cur_req = "R11"; wr(2, 32'h0000_0000); rd(2); wr(0, 32'h0000_000A); rd(0);
    wr(3, 32'h5A00_0000); rd(3);

    cur_req = "R2";  pres[1:0] = 2'b11; rd(2, 2); pres[1:0] = 2'b01; rd(2);
    mrl[1] = 1'b1; rd(3, 2); mrl[1] = 1'b0; rd(3);

    cur_req = "R5";  iso[2] = 1'b1; rd(4); iso[2] = 1'b0; con[2] = 1'b1; rd(4);
    con[2] = 1'b0; btn[2] = 1'b0; mrl[2] = 1'b1; rd(4);

    cur_req = "R3";  wr(2, 32'h001F_0000); btn[0] = 1'b1; rd(2, 2);
    btn[0] = 1'b0; rd(2, 2); wr(2, 32'h001F_0000);
    iso[0] = 1'b1; rd(2); iso[0] = 1'b0; rd(2); con[0] = 1'b1; rd(2, 2); con[0] = 1'b0; rd(2);

    cur_req = "R4";  wr(2, 32'h0000_0000); rd(2); wr(2, 32'h0004_0000); rd(2);
    btn[0] = 1'b1; wr(2, 32'h0004_0000); rd(2); btn[0] = 1'b0;
    wr(2, 32'h0010_0000); rd(2);

    cur_req = "R7";  wr(0, 32'h0000_0000); rd(1, 2); wr(1, 32'hFFFF_FFFF); rd(1);
    wr(3, 32'h1F00_0000); mrl[1] = 1'b1; rd(1, 2); mrl[1] = 1'b0;
    cur_req = "R8";  wr(0, 32'h0000_0001); rd(1, 2); wr(0, 32'h0000_0000); rd(1);

    cur_req = "R9";  wr(0, 32'h0000_0001); wr(3, 32'h0000_0000); mrl[1] = 1'b1; rd(3, 2);
    wr(3, 32'h2000_0000); rd(3); wr(0, 32'h0000_0000); con[3] = 1'b1; rd(5, 2);
    wr(5, 32'h4000_0000); rd(5); arb = 1'b1; rd(0); arb = 1'b0; rd(0);

    cur_req = "R10"; wr(0, 32'h0003_0004); cdone = 1'b1; rd(0); cdone = 1'b0; rd(0, 2);
    wr(0, 32'h0001_0000); rd(0); cdone = 1'b1; arb = 1'b1; wr(0, 32'h0003_0000);
    cdone = 1'b0; arb = 1'b0; rd(0); rd(1);

    cur_req = "R6";  wr(0, 32'hFFFF_FFFF); rd(0); wr(4, 32'hFFFF_FFFF); rd(4);
    rd(7); wr(7, 32'hFFFF_FFFF); rd(0);

    cur_req = "R4";
    for (int i = 0; i < 4000; i++) begin
      pres  = ($urandom_range(0, 9) == 0) ? 2*N'($urandom) : pres;
      btn   = N'($urandom) & N'($urandom);
      mrl   = ($urandom_range(0, 5) == 0) ? N'($urandom) : mrl;
      iso   = N'($urandom) & N'($urandom) & N'($urandom);
      con   = N'($urandom) & N'($urandom) & N'($urandom);
      cdone = ($urandom_range(0, 7) == 0);
      arb   = ($urandom_range(0, 15) == 0);
      we    = ($urandom_range(0, 3) == 0);
      addr  = AW'($urandom_range(0, 7));
      wdata = $urandom;
      cyc();
    end
    we = 1'b0;
    cyc(2);
    run = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule